// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps the processor core in reset after a power-on, brown-out, wake-from-sleep or external reset until the required start-up delays have elapsed. The delay has two chained stages. A power-up timer counts pulses of a slow reference tick. An oscillator start-up timer then counts periods of the main oscillator. Which stages run depends on the latched oscillator mode (RC or crystal), the power-up-timer enable and the kind of event that started the sequence.

The timers start from the power-on or brown-out event, not from release of the external reset pin. If the pin is still held low when both timers have expired, the core leaves reset as soon as the pin goes high, with no further wait. The analog detectors, the oscillator and the sleep logic sit outside this block. Their outputs arrive here as single-cycle pulses and levels that are already synchronous to `clk`. Each oscillator period is presented as one `osc_tick` pulse.

Top module: `rst_timeout_seq`

## Requirements
- R1: After `rst_n` is released, and until the first power-on or brown-out pulse, `core_rst` is 1 and `seq_done` is 0.
- R2: Crystal mode (`osc_rc`=0) with `pwrt_en`=1: after a power-on pulse, `seq_done` stays 0 until PWRT_TICKS `slow_tick` pulses and then OST_CYCLES `osc_tick` pulses have been seen. It becomes 1 on the clock edge that samples the last oscillator tick. Oscillator ticks seen during the first stage are not counted.
- R3: Crystal mode with `pwrt_en`=0: only OST_CYCLES `osc_tick` pulses are needed, and `slow_tick` has no effect.
- R4: RC mode (`osc_rc`=1) with `pwrt_en`=1: only PWRT_TICKS `slow_tick` pulses are needed, and `osc_tick` has no effect.
- R5: RC mode with `pwrt_en`=0: `seq_done` is 1 on the clock edge after the power-on pulse is sampled.
- R6: A brown-out pulse produces the same delays as a power-on pulse.
- R7: A wake pulse while `seq_done`=1 starts OST_CYCLES oscillator ticks of reset in crystal mode, and has no effect in RC mode. A wake pulse while the sequence is still running is ignored.
- R8: While `ext_rst_n` is 0, `core_rst` is 1 and the timers keep counting. Once `seq_done` is 1, `core_rst` falls in the same cycle the pin goes high.
- R9: A power-on or brown-out pulse at any point restarts the sequence from its first stage with cleared counters. Such a pulse takes priority over a simultaneous wake pulse.
- R10: `osc_rc` and `pwrt_en` are sampled when a sequence starts. Later changes to them do not alter the sequence in progress.
- R11: `seq_done` falls only in the cycle after a power-on, brown-out or wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| slow_tick | input | 1 | One-cycle pulse per power-up-timer period |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| osc_rc | input | 1 | 1 = RC oscillator, 0 = crystal mode |
| pwrt_en | input | 1 | 1 = power-up timer enabled |
| por_evt | input | 1 | Power-on pulse |
| bor_evt | input | 1 | Brown-out pulse |
| wake_evt | input | 1 | Wake-from-sleep pulse |
| ext_rst_n | input | 1 | External reset pin, active low, synchronized |
| core_rst | output | 1 | Reset to the core, active high |
| seq_done | output | 1 | All required time-outs have expired |

## Verification
All four combinations of oscillator mode and timer enable are driven after a power-on pulse. Each one separates which stage counted and which tick stream was ignored. The wrong kind of tick is fed deliberately during each stage to show it is not counted. A brown-out run in crystal mode shows that brown-out shares the power-on path. Wake pulses in both modes, and during an active sequence, separate the short wake path from the full one. Restart pulses in both stages, a pin held past expiry, and mode changes in mid-sequence separate restart, pin gating and input latching from plain counting.

// File: rtl/rts_pkg.sv
// Shared types for the reset time-out sequencer.
// Assumes nothing beyond a two-bit state encoding.
package rts_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // no power-on seen yet
        ST_PWRT = 2'd1,   // power-up timer counting slow ticks
        ST_OST  = 2'd2,   // start-up timer counting oscillator ticks
        ST_RUN  = 2'd3    // all time-outs expired
    } seq_state_t;
endpackage

// File: rtl/rts_tick_counter.sv
// Counts qualifying tick pulses while enabled and flags the pulse that
// completes LIMIT of them. Assumes tick is a one-cycle pulse and LIMIT >= 1.
module rts_tick_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);
    assign expire  = run && tick && !clear && at_last;

    // Tick count: zeroed when idle or cleared, wraps after the final tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rts_stage_fsm.sv
// Chooses and sequences the time-out stages. It latches the mode and
// enable when a sequence starts. Power-on and brown-out take priority
// over wake. Assumes event inputs are synchronous one-cycle pulses.
module rts_stage_fsm
    import rts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_evt,
    input  logic       bor_evt,
    input  logic       wake_evt,
    input  logic       osc_rc,
    input  logic       pwrt_en,
    input  logic       pwrt_exp,
    input  logic       ost_exp,
    output seq_state_t state,
    output logic       pwrt_run,
    output logic       ost_run,
    output logic       pwrt_clr,
    output logic       ost_clr
);
    seq_state_t nxt;
    logic       rc_q;
    logic       restart;
    logic       wake_go;

    assign restart  = por_evt || bor_evt;
    assign wake_go  = wake_evt && !restart && (state == ST_RUN);
    assign pwrt_run = (state == ST_PWRT);
    assign ost_run  = (state == ST_OST);
    assign pwrt_clr = restart;
    assign ost_clr  = restart || wake_go;

    // Next-stage selection from the event, the latched mode and the expiries.
    always_comb begin
        nxt = state;
        if (restart) begin
            if (pwrt_en)      nxt = ST_PWRT;
            else if (!osc_rc) nxt = ST_OST;
            else              nxt = ST_RUN;
        end else if (wake_go) begin
            nxt = osc_rc ? ST_RUN : ST_OST;
        end else begin
            case (state)
                ST_PWRT: if (pwrt_exp) nxt = rc_q ? ST_RUN : ST_OST;
                ST_OST:  if (ost_exp)  nxt = ST_RUN;
                default: nxt = state;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // Latch the oscillator mode whenever a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rc_q <= 1'b0;
        else if (restart || wake_go)  rc_q <= osc_rc;
    end
endmodule

// File: rtl/rst_timeout_seq.sv
// Top of the reset time-out sequencer. It holds the core in reset until
// the chosen delays expire and while the external pin is low. Assumes
// every input is already synchronous to clk.
module rst_timeout_seq
    import rts_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic osc_tick,
    input  logic osc_rc,
    input  logic pwrt_en,
    input  logic por_evt,
    input  logic bor_evt,
    input  logic wake_evt,
    input  logic ext_rst_n,
    output logic core_rst,
    output logic seq_done
);
    seq_state_t state;
    logic pwrt_run, ost_run, pwrt_clr, ost_clr;
    logic pwrt_exp, ost_exp;

    rts_stage_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_evt  (por_evt),
        .bor_evt  (bor_evt),
        .wake_evt (wake_evt),
        .osc_rc   (osc_rc),
        .pwrt_en  (pwrt_en),
        .pwrt_exp (pwrt_exp),
        .ost_exp  (ost_exp),
        .state    (state),
        .pwrt_run (pwrt_run),
        .ost_run  (ost_run),
        .pwrt_clr (pwrt_clr),
        .ost_clr  (ost_clr)
    );

    rts_tick_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pwrt_clr),
        .run    (pwrt_run),
        .tick   (slow_tick),
        .expire (pwrt_exp)
    );

    rts_tick_counter #(.LIMIT(OST_CYCLES)) u_ost (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ost_clr),
        .run    (ost_run),
        .tick   (osc_tick),
        .expire (ost_exp)
    );

    // Outputs: done once the run stage is reached; the pin gates reset directly.
    assign seq_done = (state == ST_RUN);
    assign core_rst = !seq_done || !ext_rst_n;
endmodule

// File: rtl/rts_checker.sv
// Temporal checks on the sequencer ports, attached by bind.
module rts_checker (
    input logic clk,
    input logic rst_n,
    input logic slow_tick,
    input logic osc_tick,
    input logic osc_rc,
    input logic pwrt_en,
    input logic por_evt,
    input logic bor_evt,
    input logic wake_evt,
    input logic ext_rst_n,
    input logic core_rst,
    input logic seq_done
);
    // R8: a low pin always holds the core in reset
    a_r8_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |-> core_rst);

    // R5: RC mode without power-up timer finishes on the next edge
    a_r5_rc_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ((por_evt || bor_evt) && osc_rc && !pwrt_en) |=> seq_done);

    // R9: a restart with any stage enabled clears done
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((por_evt || bor_evt) && (pwrt_en || !osc_rc)) |=> !seq_done);

    // R7: crystal-mode wake from the run state re-enters reset
    a_r7_wake_xtal: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !por_evt && !bor_evt && seq_done && !osc_rc) |=> !seq_done);

    // R2: done only rises after a tick or an event
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(slow_tick || osc_tick || por_evt || bor_evt || wake_evt));

    // R11: done only falls after an event
    a_r11_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_done) |-> $past(por_evt || bor_evt || wake_evt));
endmodule

bind rst_timeout_seq rts_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .osc_tick  (osc_tick),
    .osc_rc    (osc_rc),
    .pwrt_en   (pwrt_en),
    .por_evt   (por_evt),
    .bor_evt   (bor_evt),
    .wake_evt  (wake_evt),
    .ext_rst_n (ext_rst_n),
    .core_rst  (core_rst),
    .seq_done  (seq_done)
);

// File: tb/sim_rst_timeout_seq.sv
module sim_rst_timeout_seq;
    localparam int NP = 6;
    localparam int NO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0, osc_tick = 1'b0;
    logic osc_rc = 1'b0, pwrt_en = 1'b1;
    logic por_evt = 1'b0, bor_evt = 1'b0, wake_evt = 1'b0;
    logic ext_rst_n = 1'b1;
    logic core_rst, seq_done;
    int   n_chk = 0, n_err = 0;
    bit   ended = 1'b0;

    always #10 clk = ~clk;

    rst_timeout_seq #(.PWRT_TICKS(NP), .OST_CYCLES(NO)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .osc_tick(osc_tick),
        .osc_rc(osc_rc), .pwrt_en(pwrt_en), .por_evt(por_evt), .bor_evt(bor_evt),
        .wake_evt(wake_evt), .ext_rst_n(ext_rst_n), .core_rst(core_rst),
        .seq_done(seq_done)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic rst_e, input logic done_e);
        chk({req, " core_rst"}, core_rst, rst_e);
        chk({req, " seq_done"}, seq_done, done_e);
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
        end
    endtask

    task automatic osc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
    endtask

    task automatic pulse_por();
        @(negedge clk) por_evt = 1'b1;
        @(negedge clk) por_evt = 1'b0;
    endtask

    task automatic pulse_bor();
        @(negedge clk) bor_evt = 1'b1;
        @(negedge clk) bor_evt = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_evt = 1'b1;
        @(negedge clk) wake_evt = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_out("R1 idle", 1'b1, 1'b0);
        slow(NP); osc(NO);
        chk_out("R1 ticks before power-on", 1'b1, 1'b0);
    endtask

    task automatic t_xtal_pwrt();
        osc_rc = 1'b0; pwrt_en = 1'b1;
        pulse_por();
        chk_out("R2 after event", 1'b1, 1'b0);
        osc(NO);                     // not counted during first stage
        slow(NP - 1);
        chk_out("R2 one slow tick short", 1'b1, 1'b0);
        slow(1);
        chk_out("R2 in second stage", 1'b1, 1'b0);
        osc(NO - 1);
        chk_out("R2 one osc tick short", 1'b1, 1'b0);
        osc(1);
        chk_out("R2 complete", 1'b0, 1'b1);
    endtask

    task automatic t_xtal_nopwrt();
        osc_rc = 1'b0; pwrt_en = 1'b0;
        pulse_por();
        slow(NP + 2);
        chk_out("R3 slow ticks ignored", 1'b1, 1'b0);
        osc(NO - 1);
        chk_out("R3 one short", 1'b1, 1'b0);
        osc(1);
        chk_out("R3 complete", 1'b0, 1'b1);
    endtask

    task automatic t_rc_pwrt();
        osc_rc = 1'b1; pwrt_en = 1'b1;
        pulse_por();
        osc(NO + 2);
        chk_out("R4 osc ticks ignored", 1'b1, 1'b0);
        slow(NP - 1);
        chk_out("R4 one short", 1'b1, 1'b0);
        slow(1);
        chk_out("R4 complete without start-up timer", 1'b0, 1'b1);
    endtask

    task automatic t_rc_nopwrt();
        osc_rc = 1'b1; pwrt_en = 1'b1;
        pulse_por(); slow(2);        // mid-sequence
        pwrt_en = 1'b0;
        @(negedge clk) por_evt = 1'b1;
        @(negedge clk) por_evt = 1'b0;
        chk_out("R5 immediate", 1'b0, 1'b1);
    endtask

    task automatic t_brownout();
        osc_rc = 1'b0; pwrt_en = 1'b1;
        pulse_bor();
        slow(NP - 1);
        chk_out("R6 brown-out first stage", 1'b1, 1'b0);
        slow(1); osc(NO - 1);
        chk_out("R6 brown-out second stage", 1'b1, 1'b0);
        osc(1);
        chk_out("R6 brown-out complete", 1'b0, 1'b1);
    endtask

    task automatic t_wake();
        // starts from the run state in crystal mode
        osc_rc = 1'b0;
        pulse_wake();
        chk_out("R7 crystal wake enters reset", 1'b1, 1'b0);
        slow(NP);
        osc(NO - 1);
        chk_out("R7 crystal wake one short", 1'b1, 1'b0);
        osc(1);
        chk_out("R7 crystal wake complete", 1'b0, 1'b1);
        osc_rc = 1'b1;
        pulse_wake();
        chk_out("R7 RC wake no effect", 1'b0, 1'b1);
        // wake during first stage is ignored
        osc_rc = 1'b0; pwrt_en = 1'b1;
        pulse_por(); slow(2);
        pulse_wake();
        osc(NO);
        chk_out("R7 wake ignored mid-sequence", 1'b1, 1'b0);
        slow(NP - 3);
        chk_out("R7 first stage still counting", 1'b1, 1'b0);
        slow(1); osc(NO);
        chk_out("R7 sequence completes normally", 1'b0, 1'b1);
    endtask

    task automatic t_pin();
        osc_rc = 1'b1; pwrt_en = 1'b1;
        @(negedge clk) ext_rst_n = 1'b0;
        pulse_por();
        slow(NP);
        chk_out("R8 pin low after expiry", 1'b1, 1'b1);
        @(negedge clk) ext_rst_n = 1'b1;
        #1;
        chk("R8 release same cycle", core_rst, 1'b0);
        @(negedge clk) ext_rst_n = 1'b0;
        #1;
        chk_out("R8 pin low while running", 1'b1, 1'b1);
        @(negedge clk) ext_rst_n = 1'b1;
    endtask

    task automatic t_restart();
        osc_rc = 1'b0; pwrt_en = 1'b1;
        pulse_por(); slow(NP - 2);
        pulse_bor();
        slow(NP - 1);
        chk_out("R9 restart clears first stage", 1'b1, 1'b0);
        slow(1); osc(NO - 2);
        // restart in second stage with power-on and simultaneous wake
        @(negedge clk) begin por_evt = 1'b1; wake_evt = 1'b1; end
        @(negedge clk) begin por_evt = 1'b0; wake_evt = 1'b0; end
        osc(NO);
        chk_out("R9 restart returns to first stage", 1'b1, 1'b0);
        slow(NP); osc(NO - 1);
        chk_out("R9 second stage recounted", 1'b1, 1'b0);
        osc(1);
        chk_out("R9 complete after restart", 1'b0, 1'b1);
    endtask

    task automatic t_latch();
        osc_rc = 1'b1; pwrt_en = 1'b1;
        pulse_por();
        osc_rc = 1'b0; pwrt_en = 1'b0;
        slow(NP);
        chk_out("R10 latched RC mode skips start-up", 1'b0, 1'b1);
    endtask

    task automatic t_fall();
        osc_rc = 1'b0; pwrt_en = 1'b1;
        slow(3); osc(3);
        chk_out("R11 ticks do not drop done", 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_xtal_pwrt();
        t_xtal_nopwrt();
        t_rc_pwrt();
        t_rc_nopwrt();
        t_fall();
        t_xtal_pwrt();
        t_wake();
        t_brownout();
        t_pin();
        t_restart();
        t_latch();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule